// File: doc/BRIEF.md
# Privileged Interrupt Selector

This block decides, once per cycle, whether a hart must divert to an interrupt handler and which interrupt that is. It masks the pending vector with the enable vector and splits the result into two groups using a delegation mask. Bits that are not delegated belong to the machine group. Delegated bits belong to the supervisor group. Each group has its own privilege-dependent enable rule. The machine group is tested first. Inside a group, the lowest-numbered bit wins.

The block also owns the timer compare register and the machine timer pending bit derived from it. A free-running real-time count is compared with the stored compare value. Once the count reaches the compare value, the pending bit is set and stays set until software writes the compare register again.

The take strobe and the cause code are registered. They are only raised when the core signals that it is at an instruction boundary. All pins are plain level signals: the selector has no data stream and no back-pressure. The core samples the strobe on any cycle.

Top module: `irq_sel_top`

## Requirements
- R1: An interrupt is a candidate only when its bit is set in both the effective pending vector and the enable vector. The effective pending vector is `irq_pend` with bit MTIP_BIT replaced by the internal timer pending bit.
- R2: A candidate whose bit is clear in `irq_deleg` belongs to the machine group. A candidate whose bit is set belongs to the supervisor group.
- R3: The machine group may be taken when `priv` is 0, 1 or 2. When `priv` is 3 (machine), it may be taken only if `m_gie` is 1.
- R4: The supervisor group may be taken when `priv` is 0 (user), or when `priv` is 1 (supervisor) and `s_gie` is 1. It is never taken when `priv` is 2 or 3.
- R5: A takeable machine group wins over the supervisor group. Within the chosen group, the lowest-numbered candidate bit is reported.
- R6: When `take_o` is 1, `cause_o` has bit XLEN-1 set, the winning bit index in its low bits, and zeros elsewhere. When `take_o` is 0, `cause_o` is zero.
- R7: When `rtc` is greater than or equal to the stored compare value, `mtip_o` becomes 1 on the next edge. It then stays 1 while the compare register is not written, even if `rtc` falls below the compare value. The input bit `irq_pend[MTIP_BIT]` has no effect.
- R8: A cycle with `cmp_wr` = 1 loads `cmp_wdata` and clears `mtip_o` at that edge. The comparison against the new value takes effect from the following edge.
- R9: `take_o` and `cause_o` are registered. They reflect the inputs present before the previous edge. `take_o` is 1 only if `insn_bnd` was 1 at that edge.
- R10: During and after reset, `take_o` = 0, `cause_o` = 0 and `mtip_o` = 0. The compare register resets to all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| priv | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine |
| m_gie | input | 1 | Machine global interrupt enable |
| s_gie | input | 1 | Supervisor global interrupt enable |
| irq_pend | input | NIRQ | Pending interrupt lines (bit MTIP_BIT ignored) |
| irq_en | input | NIRQ | Per-interrupt enables |
| irq_deleg | input | NIRQ | Delegation mask, 1 = supervisor group |
| rtc | input | TW | Real-time count |
| cmp_wr | input | 1 | Write strobe for the timer compare register |
| cmp_wdata | input | TW | Value written to the compare register |
| insn_bnd | input | 1 | Core is at an instruction boundary |
| take_o | output | 1 | Take-interrupt strobe |
| cause_o | output | XLEN | Cause code with interrupt flag in the top bit |
| mtip_o | output | 1 | Machine timer pending bit |

## Verification
The selection path uses a single register stage. The bench therefore drives `priv`, the enables and the three vectors at a falling edge, waits for exactly one rising edge, and compares `take_o` and `cause_o` one time unit later.

The timer bit takes two edges after a compare write to reflect the new value: the first edge clears it and the second edge re-evaluates it. A timer interrupt then appears in `take_o` one edge after that. The bench samples `mtip_o` after each of those edges and samples the take output only after the third edge.

Expected values come from an arithmetic model of the group and priority rules. The sweep covers every privilege level and global-enable pair against a range of vector patterns.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;
  typedef enum logic [1:0] {
    PRIV_USER  = 2'd0,
    PRIV_SUPER = 2'd1,
    PRIV_RSVD  = 2'd2,
    PRIV_MACH  = 2'd3
  } priv_e;

  localparam int GRP_MACH  = 0;
  localparam int GRP_SUPER = 1;
  localparam int NGRP      = 2;
endpackage

// File: rtl/irq_timer_cmp.sv
module irq_timer_cmp #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] rtc,
  input  logic          cmp_wr,
  input  logic [TW-1:0] cmp_wdata,
  output logic          mtip
);
  logic [TW-1:0] cmp_q;
  logic          mtip_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_q  <= '1;
      mtip_q <= 1'b0;
    end else if (cmp_wr) begin
      cmp_q  <= cmp_wdata;
      mtip_q <= 1'b0;
    end else if (rtc >= cmp_q) begin
      mtip_q <= 1'b1;
    end
  end

  assign mtip = mtip_q;

  p_wr_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_wr |=> !mtip_q);
  p_reach_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmp_wr && rtc >= cmp_q) |=> mtip_q);
  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mtip_q && !cmp_wr) |=> mtip_q);
endmodule

// File: rtl/irq_lowest_pick.sv
module irq_lowest_pick #(
  parameter int N = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  vec,
  output logic          hit,
  output logic [IW-1:0] idx
);
  always_comb begin
    hit = |vec;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/irq_sel_top.sv
module irq_sel_top
  import irq_sel_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int NIRQ     = 8,
  parameter int TW       = 16,
  parameter int MTIP_BIT = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      priv,
  input  logic            m_gie,
  input  logic            s_gie,
  input  logic [NIRQ-1:0] irq_pend,
  input  logic [NIRQ-1:0] irq_en,
  input  logic [NIRQ-1:0] irq_deleg,
  input  logic [TW-1:0]   rtc,
  input  logic            cmp_wr,
  input  logic [TW-1:0]   cmp_wdata,
  input  logic            insn_bnd,
  output logic            take_o,
  output logic [XLEN-1:0] cause_o,
  output logic            mtip_o
);
  localparam int IW = (NIRQ > 1) ? $clog2(NIRQ) : 1;

  logic            mtip;
  logic [NIRQ-1:0] pend_eff, cand;
  logic [NIRQ-1:0] grp_vec [NGRP];
  logic            grp_hit [NGRP];
  logic [IW-1:0]   grp_idx [NGRP];
  logic            m_ok, s_ok, take_d;
  logic [IW-1:0]   win_idx;
  logic [XLEN-1:0] cause_d;
  logic            take_q;
  logic [XLEN-1:0] cause_q;

  irq_timer_cmp #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .rtc(rtc),
    .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata), .mtip(mtip)
  );

  always_comb begin
    pend_eff = irq_pend;
    pend_eff[MTIP_BIT] = mtip;
  end

  assign cand                = pend_eff & irq_en;
  assign grp_vec[GRP_MACH]  = cand & ~irq_deleg;
  assign grp_vec[GRP_SUPER] = cand & irq_deleg;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    irq_lowest_pick #(.N(NIRQ)) u_pick (
      .vec(grp_vec[g]), .hit(grp_hit[g]), .idx(grp_idx[g])
    );
  end

  always_comb begin
    m_ok = (priv != PRIV_MACH) || m_gie;
    s_ok = (priv == PRIV_USER) || ((priv == PRIV_SUPER) && s_gie);
  end

  always_comb begin
    take_d  = 1'b0;
    win_idx = '0;
    if (m_ok && grp_hit[GRP_MACH]) begin
      take_d  = 1'b1;
      win_idx = grp_idx[GRP_MACH];
    end else if (s_ok && grp_hit[GRP_SUPER]) begin
      take_d  = 1'b1;
      win_idx = grp_idx[GRP_SUPER];
    end
    cause_d = '0;
    cause_d[XLEN-1] = 1'b1;
    cause_d[IW-1:0] = win_idx;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      take_q  <= 1'b0;
      cause_q <= '0;
    end else if (take_d && insn_bnd) begin
      take_q  <= 1'b1;
      cause_q <= cause_d;
    end else begin
      take_q  <= 1'b0;
      cause_q <= '0;
    end
  end

  assign take_o  = take_q;
  assign cause_o = cause_q;
  assign mtip_o  = mtip;

  p_flag_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> cause_o[XLEN-1]);
  p_idle_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !take_o |-> (cause_o == '0));
  p_needs_bnd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> $past(insn_bnd));
  p_needs_cand_r1: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> ($past(cand) != '0));
  p_sup_blocked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (priv[1] && grp_hit[GRP_SUPER] && !grp_hit[GRP_MACH]) |=> !take_o);
endmodule

// File: tb/tb_irq_sel_top.sv
module tb_irq_sel_top;
  localparam int CLK_PERIOD = 10;
  localparam int XLEN = 32;
  localparam int NIRQ = 8;
  localparam int TW   = 16;
  localparam int MTB  = 7;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [1:0]      priv;
  logic            m_gie, s_gie;
  logic [NIRQ-1:0] irq_pend, irq_en, irq_deleg;
  logic [TW-1:0]   rtc;
  logic            cmp_wr;
  logic [TW-1:0]   cmp_wdata;
  logic            insn_bnd;
  logic            take_o;
  logic [XLEN-1:0] cause_o;
  logic            mtip_o;

  int total = 0;
  int bad   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_sel_top #(.XLEN(XLEN), .NIRQ(NIRQ), .TW(TW), .MTIP_BIT(MTB)) dut (
    .clk(clk), .rst_n(rst_n), .priv(priv), .m_gie(m_gie), .s_gie(s_gie),
    .irq_pend(irq_pend), .irq_en(irq_en), .irq_deleg(irq_deleg),
    .rtc(rtc), .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata), .insn_bnd(insn_bnd),
    .take_o(take_o), .cause_o(cause_o), .mtip_o(mtip_o)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [XLEN:0] model(input int pv, input bit mg, input bit sg,
      input logic [NIRQ-1:0] pd, input logic [NIRQ-1:0] en,
      input logic [NIRQ-1:0] dg, input bit mt, input bit bnd);
    logic [NIRQ-1:0] c;
    int m_i, s_i;
    bit m_ok, s_ok;
    c = pd & en;
    c[MTB] = mt & en[MTB];
    m_i = -1; s_i = -1;
    for (int i = NIRQ - 1; i >= 0; i--) begin
      if (c[i] && !dg[i]) m_i = i;
      if (c[i] && dg[i])  s_i = i;
    end
    m_ok = (pv < 3) || mg;
    s_ok = (pv == 0) || (pv == 1 && sg);
    if (!bnd) return '0;
    if (m_ok && m_i >= 0) return {1'b1, 1'b1, (XLEN-1)'(m_i)};
    if (s_ok && s_i >= 0) return {1'b1, 1'b1, (XLEN-1)'(s_i)};
    return '0;
  endfunction

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [XLEN:0] e;
    rst_n = 0; priv = 0; m_gie = 0; s_gie = 0;
    irq_pend = '1; irq_en = '1; irq_deleg = '0;
    rtc = '0; cmp_wr = 0; cmp_wdata = '0; insn_bnd = 1;
    repeat (3) tick();
    check("R10 take in reset", 64'(take_o), 0);
    check("R10 cause in reset", 64'(cause_o), 0);
    check("R10 mtip in reset", 64'(mtip_o), 0);
    irq_pend = '0;
    @(negedge clk); rst_n = 1;
    tick();
    check("R10 mtip after reset (cmp all ones)", 64'(mtip_o), 0);
    check("R10 take after reset", 64'(take_o), 0);

    // R1 R2 R3 R4 R5 R6 R9 sweep (mtip stays 0: rtc 0 < compare)
    for (int pv = 0; pv < 4; pv++) begin
      for (int ge = 0; ge < 4; ge++) begin
        for (int k = 0; k < 40; k++) begin
          @(negedge clk);
          priv = 2'(pv); m_gie = ge[0]; s_gie = ge[1];
          irq_pend  = NIRQ'((k * 29 + 3) ^ (k * 7));
          irq_en    = NIRQ'(k * 53 + 11) | NIRQ'(k[0] ? 8'h80 : 8'h00);
          irq_deleg = NIRQ'((k * 71 + 5) >> (k % 3));
          insn_bnd  = (k % 5) != 0;
          e = model(pv, ge[0], ge[1], irq_pend, irq_en, irq_deleg, 1'b0, insn_bnd);
          tick();
          check($sformatf("R5 R3 R4 R9 take pv=%0d ge=%0d k=%0d", pv, ge, k), 64'(take_o), 64'(e[XLEN]));
          check($sformatf("R6 R1 R2 cause pv=%0d ge=%0d k=%0d", pv, ge, k), 64'(cause_o), 64'(e[XLEN-1:0]));
        end
      end
    end

    // R5 machine over supervisor even with a lower supervisor bit
    @(negedge clk);
    priv = 0; m_gie = 0; s_gie = 1; insn_bnd = 1;
    irq_pend = 8'h12; irq_en = 8'hFF; irq_deleg = 8'h02;
    tick();
    check("R5 machine group first", 64'(cause_o), 64'h80000004);
    // R4 reserved level 2 blocks supervisor only
    @(negedge clk); priv = 2; irq_pend = 8'h02;
    tick();
    check("R4 supervisor blocked at level 2", 64'(take_o), 0);
    // R7 input bit MTIP_BIT ignored
    @(negedge clk); priv = 0; irq_pend = 8'h80; irq_deleg = 8'h00;
    tick();
    check("R7 pend input bit 7 ignored", 64'(take_o), 0);

    // R8 R7 timer behaviour
    @(negedge clk); irq_pend = 8'h00; irq_en = 8'h80; rtc = 16'd5;
    cmp_wr = 1; cmp_wdata = 16'd10;
    tick();
    check("R8 mtip clear after write", 64'(mtip_o), 0);
    @(negedge clk); cmp_wr = 0;
    tick();
    check("R7 rtc below compare", 64'(mtip_o), 0);
    @(negedge clk); rtc = 16'd10;
    tick();
    check("R7 rtc equal compare sets", 64'(mtip_o), 1);
    @(negedge clk); rtc = 16'd3;
    tick();
    check("R7 timer interrupt cause", 64'(cause_o), 64'h80000007);
    check("R7 mtip sticky", 64'(mtip_o), 1);
    @(negedge clk); cmp_wr = 1; cmp_wdata = 16'd2;
    tick();
    check("R8 write clears even when reached", 64'(mtip_o), 0);
    @(negedge clk); cmp_wr = 0;
    tick();
    check("R8 next edge re-evaluates new compare", 64'(mtip_o), 1);
    @(negedge clk); cmp_wr = 1; cmp_wdata = 16'd100;
    tick();
    @(negedge clk); cmp_wr = 0;
    tick();
    check("R8 stays clear above rtc", 64'(mtip_o), 0);
    check("R9 no take without timer", 64'(take_o), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule